// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the instruction that configures the vector length of a vector-capable core. It is given a 32-bit instruction word, the value of one general register operand and the value of the loop count register. It holds the architectural state for vector processing:

- the current vector length (VL),
- the maximum vector length (MVL),
- the vertical-first mode flag.

Control bits in the instruction decide whether MVL and VL are updated. The new VL can come from one of three places: the count register, the general register, or an immediate encoded minus one. The value is then limited to the new MVL.

For a legal instruction, the result appears one cycle after issue, with `done` high. The new VL is written back to a destination register when that register is not r0. A zero test of the new VL is reported when the record bit is set. An instruction whose primary or extended opcode does not match is flagged as illegal, and it changes nothing.

The unit is placed next to the integer execution pipe. The register file and the count register logic stay outside the unit. They supply the operand values and take the write-back.

Top module: `vlcfg_unit`

## Requirements
- R1: Instruction bits are numbered with bit 0 as the most significant (`instr[31]`). The primary opcode is in bits 0–5 (`instr[31:26]`) and must equal the parameter `PRIMARY_OP` (default 22). The extended opcode is in bits 26–30 (`instr[5:1]`) and must equal 5'b11110. If either field differs, `illegal` is high one cycle after issue, VL/MVL/vfirst keep their values, and `done`, `rt_we` and `cond_we` stay low.
- R2: While reset is asserted, and immediately after it, VL=1, MVL=1 and vfirst=0.
- R3: When the MVL-enable bit (bit 23, `instr[8]`) is 1, MVL becomes the immediate field (bits 16–21, `instr[15:10]`) plus one. When this bit is 0, MVL keeps its value.
- R4: When the VL-enable bit (bit 24, `instr[7]`) is 1, the VL source is chosen in this priority order:
  - the count register, if the count-select bit (bit 22, `instr[9]`) is 1;
  - otherwise `ra_value`, if the RA field (bits 11–15, `instr[20:16]`) is non-zero;
  - otherwise the immediate field plus one.
- R5: The stored VL is the minimum of the candidate and the new MVL (the MVL after R3 has been applied). The comparison uses the full 64-bit source value. When the VL-enable bit is 0, the candidate is the current VL, so lowering MVL also lowers VL.
- R6: Every legal instruction stores the vertical-first bit (bit 25, `instr[6]`) into vfirst.
- R7: One cycle after a legal issue, `done` pulses for one cycle. If the RT field (bits 6–10, `instr[25:21]`) is non-zero, `rt_we` is high at the same time, with `rt_addr`=RT and `rt_data` equal to the new VL zero-extended. If RT is zero, `rt_we` stays low.
- R8: When the record bit (bit 31, `instr[0]`) of a legal instruction is 1, `cond_we` is high with `done`, and `cond_zero` is 1 exactly when the new VL is zero. When the record bit is 0, `cond_we` stays low.
- R9: VL never exceeds MVL at any time out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| ra_value | input | XLEN | Value of general register RA |
| ctr_value | input | XLEN | Value of the count register |
| done | output | 1 | Legal instruction completed (one cycle after issue) |
| illegal | output | 1 | Opcode mismatch (one cycle after issue) |
| rt_we | output | 1 | Destination register write enable |
| rt_addr | output | 5 | Destination register index |
| rt_data | output | XLEN | New VL, zero-extended |
| cond_we | output | 1 | Condition flag update |
| cond_zero | output | 1 | New VL is zero |
| vl_o | output | 7 | Current VL |
| mvl_o | output | 7 | Current MVL |
| vfirst_o | output | 1 | Vertical-first mode flag |

## Verification
A table of instructions is applied back to back, and each row depends on the state left by the previous row. This shows whether the unit really carries MVL and VL across instructions.

The rows cover each source of VL:
- The immediate alone.
- A non-zero RA field with both a small and a large register value, which separates the plain pass-through from the clamp.
- The count-select bit set while RA is also non-zero, which checks the priority order.
- Count and register values of zero, which produce a zero VL and exercise the condition flag.

Further rows check three specific clamping cases:
- MVL raised and VL set in the same instruction, which shows the clamp uses the new MVL.
- MVL lowered with VL-enable off, which must still clamp VL.
- A register value with only high bits set above the MVL, which exposes any truncation before the compare.

Directed tests then cover both kinds of illegal opcode, the return of `done` to low, and a reset in the middle of a run.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

  // Immediate field width fixed by the encoding; lengths hold imm+1.
  localparam int IMM_W = 6;
  localparam int LEN_W = IMM_W + 1;

  // Extended opcode value of the configuration instruction.
  localparam logic [4:0] XO_SETLEN = 5'b11110;

  typedef struct packed {
    logic [5:0]       po;      // primary opcode
    logic [4:0]       rt;      // destination register
    logic [4:0]       ra;      // source register
    logic [IMM_W-1:0] imm;     // immediate, stored minus one
    logic             cnt_sel; // take VL from count register
    logic             mvl_en;  // update MVL
    logic             vl_en;   // update VL
    logic             vfirst;  // vertical-first mode
    logic [4:0]       xo;      // extended opcode
    logic             rec;     // record condition flag
  } vlcfg_fields_t;

endpackage

// File: rtl/vlcfg_rst_sync.sv
module vlcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter logic [5:0] PRIMARY_OP = 6'd22
) (
  input  logic          issue_valid,
  input  logic [31:0]   instr,
  output vlcfg_fields_t fld,
  output logic          legal_go,
  output logic          illegal_go
);

  logic match;

  // Field layout follows the encoding: bit 0 of the format is instr[31].
  always_comb begin
    fld.po      = instr[31:26];
    fld.rt      = instr[25:21];
    fld.ra      = instr[20:16];
    fld.imm     = instr[15:10];
    fld.cnt_sel = instr[9];
    fld.mvl_en  = instr[8];
    fld.vl_en   = instr[7];
    fld.vfirst  = instr[6];
    fld.xo      = instr[5:1];
    fld.rec     = instr[0];
  end

  always_comb begin
    match      = (fld.po == PRIMARY_OP) && (fld.xo == XO_SETLEN);
    legal_go   = issue_valid && match;
    illegal_go = issue_valid && !match;
  end

endmodule

// File: rtl/vlcfg_len_calc.sv
module vlcfg_len_calc
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vlcfg_fields_t    fld,
  input  logic [LEN_W-1:0] cur_vl,
  input  logic [LEN_W-1:0] cur_mvl,
  input  logic [XLEN-1:0]  ra_value,
  input  logic [XLEN-1:0]  ctr_value,
  output logic [LEN_W-1:0] nxt_vl,
  output logic [LEN_W-1:0] nxt_mvl
);

  localparam int PAD_W = XLEN - LEN_W;

  logic [LEN_W-1:0] imm_eff;
  logic [XLEN-1:0]  cand;
  logic [XLEN-1:0]  mvl_wide;
  logic             over;

  always_comb begin
    imm_eff = {1'b0, fld.imm} + LEN_W'(1);
  end

  // MVL is settled first; the VL clamp sees the new value.
  always_comb begin
    nxt_mvl = fld.mvl_en ? imm_eff : cur_mvl;
  end

  // Fixed-priority source pick: count register, then RA, then immediate.
  always_comb begin
    if (!fld.vl_en) begin
      cand = {{PAD_W{1'b0}}, cur_vl};
    end else if (fld.cnt_sel) begin
      cand = ctr_value;
    end else if (fld.ra != 5'd0) begin
      cand = ra_value;
    end else begin
      cand = {{PAD_W{1'b0}}, imm_eff};
    end
  end

  // Full-width compare so high source bits are never dropped.
  always_comb begin
    mvl_wide = {{PAD_W{1'b0}}, nxt_mvl};
    over     = cand > mvl_wide;
    nxt_vl   = over ? nxt_mvl : cand[LEN_W-1:0];
  end

endmodule

// File: rtl/vlcfg_state.sv
module vlcfg_state
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legal_go,
  input  logic             illegal_go,
  input  vlcfg_fields_t    fld,
  input  logic [LEN_W-1:0] nxt_vl,
  input  logic [LEN_W-1:0] nxt_mvl,
  output logic [LEN_W-1:0] vl_q,
  output logic [LEN_W-1:0] mvl_q,
  output logic             vfirst_q,
  output logic             done_q,
  output logic             illegal_q,
  output logic             rt_we_q,
  output logic [4:0]       rt_addr_q,
  output logic [XLEN-1:0]  rt_data_q,
  output logic             cond_we_q,
  output logic             cond_zero_q
);

  localparam int PAD_W = XLEN - LEN_W;

  logic [LEN_W-1:0] vl_d;
  logic [LEN_W-1:0] mvl_d;
  logic             vfirst_d;
  logic             done_d;
  logic             illegal_d;
  logic             rt_we_d;
  logic [4:0]       rt_addr_d;
  logic [XLEN-1:0]  rt_data_d;
  logic             cond_we_d;
  logic             cond_zero_d;
  logic             arch_en;

  // Next-state logic.
  always_comb begin
    arch_en     = legal_go;
    vl_d        = nxt_vl;
    mvl_d       = nxt_mvl;
    vfirst_d    = fld.vfirst;
    done_d      = legal_go;
    illegal_d   = illegal_go;
    rt_we_d     = legal_go && (fld.rt != 5'd0);
    rt_addr_d   = legal_go ? fld.rt : rt_addr_q;
    rt_data_d   = legal_go ? {{PAD_W{1'b0}}, nxt_vl} : rt_data_q;
    cond_we_d   = legal_go && fld.rec;
    cond_zero_d = legal_go ? (nxt_vl == '0) : cond_zero_q;
  end

  // Architectural state, updated only by a legal instruction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q     <= LEN_W'(1);
      mvl_q    <= LEN_W'(1);
      vfirst_q <= 1'b0;
    end else if (arch_en) begin
      vl_q     <= vl_d;
      mvl_q    <= mvl_d;
      vfirst_q <= vfirst_d;
    end
  end

  // Result pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      rt_we_q   <= 1'b0;
      cond_we_q <= 1'b0;
    end else begin
      done_q    <= done_d;
      illegal_q <= illegal_d;
      rt_we_q   <= rt_we_d;
      cond_we_q <= cond_we_d;
    end
  end

  // Result payload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_addr_q   <= '0;
      rt_data_q   <= '0;
      cond_zero_q <= 1'b0;
    end else begin
      rt_addr_q   <= rt_addr_d;
      rt_data_q   <= rt_data_d;
      cond_zero_q <= cond_zero_d;
    end
  end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int         XLEN       = 64,
  parameter logic [5:0] PRIMARY_OP = 6'd22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  ra_value,
  input  logic [XLEN-1:0]  ctr_value,
  output logic             done,
  output logic             illegal,
  output logic             rt_we,
  output logic [4:0]       rt_addr,
  output logic [XLEN-1:0]  rt_data,
  output logic             cond_we,
  output logic             cond_zero,
  output logic [LEN_W-1:0] vl_o,
  output logic [LEN_W-1:0] mvl_o,
  output logic             vfirst_o
);

  logic             rst_n_sync;
  vlcfg_fields_t    fld;
  logic             legal_go;
  logic             illegal_go;
  logic [LEN_W-1:0] nxt_vl;
  logic [LEN_W-1:0] nxt_mvl;

  vlcfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  vlcfg_decode #(.PRIMARY_OP(PRIMARY_OP)) u_decode (
    .issue_valid (issue_valid),
    .instr       (instr),
    .fld         (fld),
    .legal_go    (legal_go),
    .illegal_go  (illegal_go)
  );

  vlcfg_len_calc #(.XLEN(XLEN)) u_len_calc (
    .fld       (fld),
    .cur_vl    (vl_o),
    .cur_mvl   (mvl_o),
    .ra_value  (ra_value),
    .ctr_value (ctr_value),
    .nxt_vl    (nxt_vl),
    .nxt_mvl   (nxt_mvl)
  );

  vlcfg_state #(.XLEN(XLEN)) u_state (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .legal_go    (legal_go),
    .illegal_go  (illegal_go),
    .fld         (fld),
    .nxt_vl      (nxt_vl),
    .nxt_mvl     (nxt_mvl),
    .vl_q        (vl_o),
    .mvl_q       (mvl_o),
    .vfirst_q    (vfirst_o),
    .done_q      (done),
    .illegal_q   (illegal),
    .rt_we_q     (rt_we),
    .rt_addr_q   (rt_addr),
    .rt_data_q   (rt_data),
    .cond_we_q   (cond_we),
    .cond_zero_q (cond_zero)
  );

endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             illegal,
  input logic             rt_we,
  input logic [4:0]       rt_addr,
  input logic [XLEN-1:0]  rt_data,
  input logic             cond_we,
  input logic             cond_zero,
  input logic [LEN_W-1:0] vl_o,
  input logic [LEN_W-1:0] mvl_o,
  input logic             vfirst_o
);

  localparam int PAD_W = XLEN - LEN_W;

  // R9
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= mvl_o);

  // R1
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(vl_o) && $stable(mvl_o) && $stable(vfirst_o)));

  // R1
  illegal_no_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !rt_we && !cond_we));

  // R7
  rt_write_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |-> (done && rt_addr != 5'd0 && rt_data == {{PAD_W{1'b0}}, vl_o}));

  // R8
  cond_matches_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_we |-> (done && (cond_zero == (vl_o == '0))));

  // R7
  state_moves_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(vl_o) && $stable(mvl_o)));

  // R2
  reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vl_o == LEN_W'(1) && mvl_o == LEN_W'(1) && !vfirst_o));

endmodule

bind vlcfg_unit vlcfg_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .illegal   (illegal),
  .rt_we     (rt_we),
  .rt_addr   (rt_addr),
  .rt_data   (rt_data),
  .cond_we   (cond_we),
  .cond_zero (cond_zero),
  .vl_o      (vl_o),
  .mvl_o     (mvl_o),
  .vfirst_o  (vfirst_o)
);

// File: tb/test_vlcfg_unit.sv
`timescale 1ns/1ps
module test_vlcfg_unit;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            issue_valid;
  logic [31:0]     instr;
  logic [XLEN-1:0] ra_value;
  logic [XLEN-1:0] ctr_value;
  logic            done, illegal, rt_we, cond_we, cond_zero, vfirst_o;
  logic [4:0]      rt_addr;
  logic [XLEN-1:0] rt_data;
  logic [6:0]      vl_o, mvl_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vlcfg_unit #(.XLEN(XLEN)) i_vlcfg_unit (
    .clk, .rst_n, .issue_valid, .instr, .ra_value, .ctr_value,
    .done, .illegal, .rt_we, .rt_addr, .rt_data, .cond_we, .cond_zero,
    .vl_o, .mvl_o, .vfirst_o
  );

  typedef struct packed {
    logic        ms, vs, vf, cv, rc;
    logic [4:0]  rt, ra;
    logic [5:0]  imm;
    logic [15:0] raval, ctrval;
    logic [6:0]  evl, emvl;
  } vec_t;

  // Rows run in order; each starts from the state the previous left.
  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 5'd3, 5'd0, 6'd7,  16'd0,    16'd0,    7'd8,  7'd8 },
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 5'd4, 5'd5, 6'd0,  16'd3,    16'd0,    7'd3,  7'd8 },
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 5'd0, 5'd5, 6'd0,  16'd100,  16'd0,    7'd8,  7'd8 },
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 5'd6, 5'd5, 6'd0,  16'd2,    16'd5,    7'd5,  7'd8 },
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 5'd7, 5'd0, 6'd0,  16'd0,    16'd0,    7'd0,  7'd8 },
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 5'd1, 5'd0, 6'd63, 16'd0,    16'd0,    7'd64, 7'd64},
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 5'd2, 5'd9, 6'd3,  16'd50,   16'd50,   7'd4,  7'd4 },
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 5'd0, 5'd9, 6'd20, 16'd50,   16'd50,   7'd4,  7'd4 },
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 5'd8, 5'd0, 6'd15, 16'd0,    16'd1000, 7'd16, 7'd16},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 5'd9, 5'd2, 6'd0,  16'd0,    16'd9,    7'd0,  7'd16},
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 5'd10,5'd0, 6'd0,  16'd0,    16'd0,    7'd1,  7'd1 }
  };

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt,
      input logic [4:0] ra, input logic [5:0] imm, input logic cv, input logic ms,
      input logic vs, input logic vf, input logic [4:0] xo, input logic rc);
    return {po, rt, ra, imm, cv, ms, vs, vf, xo, rc};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next fall.
  task automatic issue(input logic [31:0] w, input logic [63:0] ra, input logic [63:0] ctr);
    @(negedge clk);
    instr = w; ra_value = ra; ctr_value = ctr; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; ra_value = '0; ctr_value = '0;
    repeat (3) @(negedge clk);
    // R2 reset state while reset held
    check(vl_o == 7'd1 && mvl_o == 7'd1 && !vfirst_o, "R2 reset",
          {vl_o, mvl_o, vfirst_o}, {7'd1, 7'd1, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(vl_o == 7'd1 && mvl_o == 7'd1 && !vfirst_o && !done, "R2 after release",
          {vl_o, mvl_o, vfirst_o}, {7'd1, 7'd1, 1'b0});

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      issue(mk(6'd22, v.rt, v.ra, v.imm, v.cv, v.ms, v.vs, v.vf, 5'b11110, v.rc),
            64'(v.raval), 64'(v.ctrval));
      check(vl_o == v.evl && mvl_o == v.emvl && vfirst_o == v.vf && done && !illegal,
            $sformatf("R3/R4/R5/R6 row %0d", i),
            {vl_o, mvl_o, vfirst_o, done}, {v.evl, v.emvl, v.vf, 1'b1});
      check(rt_we == (v.rt != 0) && (!rt_we || (rt_addr == v.rt && rt_data == 64'(v.evl))),
            $sformatf("R7 row %0d", i), {rt_we, rt_addr, rt_data[15:0]},
            {(v.rt != 0), v.rt, 9'd0, v.evl});
      check(cond_we == v.rc && (!v.rc || cond_zero == (v.evl == 0)),
            $sformatf("R8 row %0d", i), {cond_we, cond_zero}, {v.rc, (v.evl == 0)});
    end

    // Known state: MVL=10, VL=10, vfirst=1
    issue(mk(6'd22, 5'd0, 5'd0, 6'd9, 1'b0, 1'b1, 1'b1, 1'b1, 5'b11110, 1'b0), 64'd0, 64'd0);
    check(vl_o == 7'd10 && mvl_o == 7'd10 && vfirst_o, "R3 setup",
          {vl_o, mvl_o}, {7'd10, 7'd10});

    // R1 wrong primary opcode
    issue(mk(6'd23, 5'd3, 5'd0, 6'd2, 1'b0, 1'b1, 1'b1, 1'b0, 5'b11110, 1'b1), 64'd0, 64'd0);
    check(illegal && !done && !rt_we && !cond_we, "R1 bad primary flags",
          {illegal, done, rt_we, cond_we}, 4'b1000);
    check(vl_o == 7'd10 && mvl_o == 7'd10 && vfirst_o, "R1 bad primary state",
          {vl_o, mvl_o, vfirst_o}, {7'd10, 7'd10, 1'b1});

    // R1 wrong extended opcode
    issue(mk(6'd22, 5'd3, 5'd0, 6'd2, 1'b0, 1'b1, 1'b1, 1'b0, 5'b11111, 1'b0), 64'd0, 64'd0);
    check(illegal && !done && !rt_we, "R1 bad xo flags", {illegal, done, rt_we}, 3'b100);
    check(vl_o == 7'd10 && mvl_o == 7'd10 && vfirst_o, "R1 bad xo state",
          {vl_o, mvl_o, vfirst_o}, {7'd10, 7'd10, 1'b1});

    // R5 only high bits plus a small low part: must clamp, not truncate
    issue(mk(6'd22, 5'd4, 5'd7, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b11110, 1'b0),
          64'h0000_0001_0000_0002, 64'd0);
    check(vl_o == 7'd10 && rt_data == 64'd10, "R5 wide source", rt_data, 64'd10);

    // R7 done lasts one cycle
    @(negedge clk);
    check(!done && !rt_we && !illegal, "R7 pulse ends", {done, rt_we, illegal}, 3'b000);

    // R2 reset in mid run
    rst_n = 1'b0;
    @(negedge clk);
    check(vl_o == 7'd1 && mvl_o == 7'd1 && !vfirst_o, "R2 mid-run reset",
          {vl_o, mvl_o, vfirst_o}, {7'd1, 7'd1, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule